// File: doc/BRIEF.md
# Chopped Drive Gate with Overcurrent Latch

This block produces one drive-allow bit for a motor commutation decoder. Drive is allowed only when three conditions hold together. The enable (chop) input must be high. A free-running digital sawtooth must lie above a speed threshold word. No overcurrent fault may be latched. A brake request overrides all of them, so the decoder can apply its braking pattern whatever the fault state.

The sawtooth is a `CNT_W`-bit up-counter. It advances once every `PRESCALE` clocks, and its wrap from all-ones to zero marks the start of a PWM period. The enable input is synchronized inside the block, and its rising edges are detected there.

An overcurrent flag sampled high trips a latch. The latch is released only at the start of a chop period, which is either an enable rising edge or a sawtooth wrap, and only if the flag is low in that cycle. Fault retries are therefore limited to the chop rate.

With `EXT_CHOP` set, the sawtooth is held at all-ones and never wraps. In that mode PWM passes every threshold below maximum, and only enable edges release the latch.

The control is a three-state machine:
- `ST_RUN`: normal gating.
- `ST_TRIP`: fault latched, drive blocked.
- `ST_BRAKE`: brake active, drive forced on.

Its transitions are:
- RUN→TRIP on the overcurrent flag.
- TRIP→RUN on a release event while the flag is low.
- RUN→BRAKE and TRIP→BRAKE on brake.
- BRAKE→TRIP when brake drops.

Top module: `chop_drive_gate`

## Requirements
- R1: While reset is low, and on the first clock edge after reset is released, `drive_allow` is 0. The machine leaves reset in `ST_RUN`, with the fault latch clear and the sawtooth at 0.
- R2: With brake low, `drive_allow` is 0 from the third clock edge after `enable` is sampled low, and it stays 0 while `enable` stays low.
- R3: With `enable` high, no fault latched and brake low, `drive_allow` is 1 only in cycles where `threshold` < sawtooth. Over any window of 2^`CNT_W`·`PRESCALE` cycles it is high for exactly (2^`CNT_W`−1−`threshold`)·`PRESCALE` cycles.
- R4: With the default counter, `threshold` = all-ones gives 0 high cycles per period. `threshold` = 0 gives all cycles except the `PRESCALE` cycles in which the sawtooth is 0.
- R5: An overcurrent flag sampled high with brake low sets the latch. `drive_allow` is 0 from the next edge, and it stays 0 after the flag drops until a release.
- R6: A latched fault is released only in a cycle with a synchronized enable rising edge or a sawtooth wrap, and only if the flag is low in that cycle. If the flag is still high at that event, the latch stays set and waits for the next event.
- R7: With `EXT_CHOP` = 1, the sawtooth is fixed at all-ones and never wraps. `drive_allow` follows enable for any `threshold` below all-ones, and only enable rising edges release the latch.
- R8: With brake sampled high, `drive_allow` is 1 from the next edge, whatever the state of enable, threshold, overcurrent flag or latch.
- R9: When brake drops, the machine enters `ST_TRIP`. `drive_allow` is 0 from the next edge until a release event as in R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Chop/enable input, asynchronous, synchronized inside |
| oc_flag | input | 1 | Synchronous overcurrent flag, active high |
| brake | input | 1 | Brake request, active high, highest priority |
| threshold | input | CNT_W | Speed threshold compared against the sawtooth |
| drive_allow | output | 1 | Registered drive permission for the commutation decoder |

## Verification
The release event and the overcurrent flag can fall in the same cycle. An enable rising edge, or a sawtooth wrap, can arrive while the fault is still present. The bench holds the flag high across an enable edge in the instance whose ramp is held. It judges the outcome by `drive_allow` staying low after the flag drops, until a later enable edge releases the latch. Brake and a latched fault are made to overlap as well: drive must be forced on during brake and must come back latched after brake ends.

// File: rtl/chop_gate_pkg.sv
package chop_gate_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_TRIP  = 2'd1,
        ST_BRAKE = 2'd2
    } gate_state_t;

endpackage

// File: rtl/en_edge_sync.sv
module en_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] shift_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            shift_q <= {shift_q[STAGES-2:0], din};
            prev_q  <= shift_q[STAGES-1];
        end
    end

    assign level = shift_q[STAGES-1];
    assign rise  = shift_q[STAGES-1] & ~prev_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise) else $error("enable edge pulse longer than one cycle"); // R6

endmodule

// File: rtl/saw_ramp.sv
module saw_ramp #(
    parameter int CNT_W    = 8,
    parameter int PRESCALE = 4,
    parameter bit HOLD_MAX = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] saw,
    output logic             wrap
);
    localparam int                PRE_W   = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [CNT_W-1:0]  SAW_MAX = '1;
    localparam logic [PRE_W-1:0]  PRE_END = PRE_W'(PRESCALE - 1);

    generate
        if (HOLD_MAX) begin : g_hold
            assign saw  = SAW_MAX;
            assign wrap = 1'b0;

            AST_HELD_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
                !wrap) else $error("held ramp produced a wrap"); // R7
        end else begin : g_run
            logic [PRE_W-1:0] pre_q;
            logic [CNT_W-1:0] saw_q;
            logic             tick;

            assign tick = (pre_q == PRE_END);

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    pre_q <= '0;
                    saw_q <= '0;
                end else begin
                    pre_q <= tick ? '0 : pre_q + 1'b1;
                    if (tick) saw_q <= saw_q + 1'b1;
                end
            end

            assign saw  = saw_q;
            assign wrap = tick && (saw_q == SAW_MAX);

            AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                wrap |=> (saw_q == '0)) else $error("ramp did not restart at zero"); // R3
            AST_SAW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
                !tick |=> $stable(saw_q)) else $error("ramp moved between prescale ticks"); // R3
        end
    endgenerate

endmodule

// File: rtl/chop_drive_gate.sv
module chop_drive_gate
    import chop_gate_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int PRESCALE    = 4,
    parameter int SYNC_STAGES = 2,
    parameter bit EXT_CHOP    = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             oc_flag,
    input  logic             brake,
    input  logic [CNT_W-1:0] threshold,
    output logic             drive_allow
);
    gate_state_t      state_q, state_n;
    logic             en_lvl, en_rise;
    logic [CNT_W-1:0] saw;
    logic             wrap;
    logic             release_ev;
    logic             pwm_on;
    logic             drive_n, drive_q;

    en_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (enable),
        .level (en_lvl),
        .rise  (en_rise)
    );

    saw_ramp #(.CNT_W(CNT_W), .PRESCALE(PRESCALE), .HOLD_MAX(EXT_CHOP)) u_ramp (
        .clk   (clk),
        .rst_n (rst_n),
        .saw   (saw),
        .wrap  (wrap)
    );

    assign release_ev = en_rise | wrap;
    assign pwm_on     = (threshold < saw);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_n;
    end

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (brake)        state_n = ST_BRAKE;
                else if (oc_flag) state_n = ST_TRIP;
            end
            ST_TRIP: begin
                if (brake)                        state_n = ST_BRAKE;
                else if (release_ev && !oc_flag)  state_n = ST_RUN;
            end
            ST_BRAKE: begin
                if (!brake) state_n = ST_TRIP;
            end
            default: state_n = ST_RUN;
        endcase
    end

    // output logic
    always_comb begin
        unique case (state_n)
            ST_BRAKE: drive_n = 1'b1;
            ST_RUN:   drive_n = en_lvl & pwm_on;
            default:  drive_n = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) drive_q <= 1'b0;
        else        drive_q <= drive_n;
    end

    assign drive_allow = drive_q;

    AST_EN_LOW_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_lvl && !brake) |=> !drive_allow) else $error("drive with enable low"); // R2
    AST_PWM_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (!brake && (threshold >= saw)) |=> !drive_allow) else $error("drive outside PWM window"); // R3
    AST_OC_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_flag && !brake) |=> !drive_allow) else $error("drive during overcurrent"); // R5
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRIP && !brake && (!release_ev || oc_flag)) |=> (state_q == ST_TRIP))
        else $error("latch released without a clean chop edge"); // R6
    AST_BRAKE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        brake |=> drive_allow) else $error("brake did not force drive"); // R8
    AST_BRAKE_EXIT_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BRAKE && !brake) |=> (state_q == ST_TRIP)) else $error("brake exit not latched"); // R9

endmodule

// File: tb/sim_chop_drive_gate.sv
module sim_chop_drive_gate;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 8;
    localparam int PRESCALE   = 4;
    localparam int PERIOD     = (1 << CNT_W) * PRESCALE;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             enable = 1'b1;
    logic             oc_flag = 1'b0;
    logic             brake = 1'b0;
    logic [CNT_W-1:0] threshold = '0;
    logic             da0, da1;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    chop_drive_gate #(.CNT_W(CNT_W), .PRESCALE(PRESCALE), .EXT_CHOP(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .oc_flag(oc_flag),
        .brake(brake), .threshold(threshold), .drive_allow(da0)
    );

    chop_drive_gate #(.CNT_W(CNT_W), .PRESCALE(PRESCALE), .EXT_CHOP(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .oc_flag(oc_flag),
        .brake(brake), .threshold(threshold), .drive_allow(da1)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        cycles(3);
        check(da0 == 1'b0, "R1 u0 in reset", da0, 0);
        check(da1 == 1'b0, "R1 u1 in reset", da1, 0);
        rst_n = 1'b1;
        cycles(1);
        check(da0 == 1'b0, "R1 u0 first edge", da0, 0);
        check(da1 == 1'b0, "R1 u1 first edge", da1, 0);
        cycles(5);
    endtask

    task automatic t_pwm(input int th, input int exp0, input string req);
        int c0 = 0;
        int c1 = 0;
        int exp1;
        threshold = CNT_W'(th);
        cycles(4);
        for (int i = 0; i < PERIOD; i++) begin
            @(negedge clk);
            c0 += int'(da0);
            c1 += int'(da1);
        end
        exp1 = (th < (1 << CNT_W) - 1) ? PERIOD : 0;
        check(c0 == exp0, req, c0, exp0);
        check(c1 == exp1, "R7 held ramp duty", c1, exp1);
    endtask

    task automatic t_enable_low();
        int hi = 0;
        threshold = '0;
        cycles(3);
        check(da1 == 1'b1, "R7 u1 on before enable drop", da1, 1);
        enable = 1'b0;
        cycles(3);
        check(da1 == 1'b0, "R2 u1 off third edge", da1, 0);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            hi += int'(da0) + int'(da1);
        end
        check(hi == 0, "R2 no drive while enable low", hi, 0);
        enable = 1'b1;
        cycles(5);
        check(da1 == 1'b1, "R2 u1 back on", da1, 1);
    endtask

    task automatic t_oc_latch();
        threshold = '0;
        oc_flag = 1'b1;
        cycles(1);
        check(da1 == 1'b0, "R5 u1 off next edge", da1, 0);
        oc_flag = 1'b0;
        cycles(30);
        check(da1 == 1'b0, "R5 u1 stays latched", da1, 0);
    endtask

    task automatic t_release_blocked();
        enable = 1'b0;
        cycles(4);
        oc_flag = 1'b1;
        enable = 1'b1;
        cycles(6);
        oc_flag = 1'b0;
        cycles(3);
        check(da1 == 1'b0, "R6 edge with fault present ignored", da1, 0);
        enable = 1'b0;
        cycles(4);
        enable = 1'b1;
        cycles(5);
        check(da1 == 1'b1, "R6 clean enable edge releases", da1, 1);
    endtask

    task automatic t_wrap_release();
        int waited = 0;
        threshold = '0;
        oc_flag = 1'b1;
        cycles(1);
        check(da0 == 1'b0, "R5 u0 off next edge", da0, 0);
        oc_flag = 1'b0;
        while (da0 == 1'b0 && waited < PERIOD + 64) begin
            @(negedge clk);
            waited++;
        end
        check(da0 == 1'b1, "R6 wrap releases u0", da0, 1);
        check(da1 == 1'b0, "R7 held ramp gives no release", da1, 0);
        enable = 1'b0;
        cycles(4);
        enable = 1'b1;
        cycles(5);
        check(da1 == 1'b1, "R7 enable edge releases u1", da1, 1);
    endtask

    task automatic t_brake();
        int lo = 0;
        enable = 1'b0;
        cycles(4);
        check(da1 == 1'b0, "R2 u1 off before brake", da1, 0);
        brake = 1'b1;
        cycles(1);
        check(da0 == 1'b1, "R8 u0 forced on", da0, 1);
        check(da1 == 1'b1, "R8 u1 forced on", da1, 1);
        oc_flag = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            lo += int'(!da0) + int'(!da1);
        end
        oc_flag = 1'b0;
        check(lo == 0, "R8 fault does not block brake", lo, 0);
        enable = 1'b1;
        cycles(6);
        brake = 1'b0;
        cycles(1);
        check(da1 == 1'b0, "R9 brake exit latched", da1, 0);
        cycles(10);
        check(da1 == 1'b0, "R9 stays latched after brake", da1, 0);
        enable = 1'b0;
        cycles(4);
        enable = 1'b1;
        cycles(5);
        check(da1 == 1'b1, "R9 enable edge releases after brake", da1, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        t_reset();
        t_pwm(192, (255 - 192) * PRESCALE, "R3 duty thr 192");
        t_pwm(64, (255 - 64) * PRESCALE, "R3 duty thr 64");
        t_pwm(0, 255 * PRESCALE, "R4 duty thr min");
        t_pwm(255, 0, "R4 duty thr max");
        t_enable_low();
        t_oc_latch();
        t_release_blocked();
        t_wrap_release();
        t_brake();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule